// File: doc/BRIEF.md
# Flash Query and Identification Read Responder

This block forms the read data a flash model returns while it sits in one of its non-array read modes. These are: reading the status byte, reading the identification words, and reading the geometry query table. A read request carries a byte address on the 32-bit bus, a mode, and an access size. One cycle later the block presents the 32-bit read word together with a valid strobe.

In query mode the table byte offset is the bus address divided by four. Most bytes come from a fixed table. The bytes that describe device size and erase geometry are computed from the two size parameters, so the table always matches the configured array.

In identification mode the low eleven address bits select one of three entries: a vendor code, a device code, or the lock bit of the erase block named by the upper address bits. Every 16-bit result is copied into both halves of a 32-bit read, which models two 16-bit devices placed side by side on one 32-bit bus.

Top module: `flash_query_resp`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first cycle after it, rd_valid is 0 and rd_data is 0.
- R2: rd_valid is 1 in the cycle after a cycle with rd_en high, and is 0 otherwise.
- R3: In query mode (rd_mode 2), offset = rd_addr >> 2. Offsets 0x10, 0x11 and 0x12 return the ASCII codes 0x51, 0x52 and 0x59. Offsets 0x31, 0x32 and 0x33 return 0x50, 0x52 and 0x49.
- R4: Query offset 0x27 returns the log2 of the size of one of the two devices, which is DEV_LOG2 - 1.
- R5: Query offsets 0x2D and 0x2E return the low byte and then the high byte of the erase-block count minus one. The count is 2^(DEV_LOG2 - ERASE_LOG2).
- R6: Query offsets 0x2F and 0x30 return the low byte and then the high byte of the erase-block size of one device in units of 256 bytes. That value is 2^(ERASE_LOG2 - 9).
- R7: Query offsets above 0x43 return 0. So do the offsets inside the table that R3 to R6 do not name.
- R8: In identification mode (rd_mode 1), index = rd_addr[10:2]. Index 0 returns 0x0000, index 1 returns 0xFFFF, and every index other than 0, 1 and 2 returns 0.
- R9: Identification index 2 returns, in bit 0, the lock bit of the block numbered rd_addr[DEV_LOG2-1:ERASE_LOG2]. The value used is the one present on lock_bits in the request cycle.
- R10: The 16-bit result is placed on the bus according to rd_size. Size 0 (byte) returns only its low byte. Size 1 (half) returns it in bits 15:0. Sizes 2 and 3 (word) return it in both bits 15:0 and bits 31:16. All other bits are 0.
- R11: In status mode (rd_mode 0), the result is the status input zero-extended to 16 bits, placed on the bus by R10.
- R12: Mode 3 returns 0. rd_data keeps its value through every cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request this cycle |
| rd_mode | input | 2 | 0 status, 1 identification, 2 query, 3 none |
| rd_size | input | 2 | 0 byte, 1 half, 2 or 3 word |
| rd_addr | input | DEV_LOG2 | Byte address within the device |
| status | input | 8 | Current status byte |
| lock_bits | input | 2^(DEV_LOG2-ERASE_LOG2) | Per-block lock flags |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
Two events can land on the same clock edge: an identification read of index 2, and a change of that block's lock bit (or of the status byte during a status read). The bench changes lock_bits and status in the same cycle it issues such reads, often on the very block being read. It then expects the returned bit to equal the value present at the request edge, not the value before or after. A behavioural model, fed the same inputs, predicts rd_valid and rd_data, and the bench compares them on every falling edge.

// File: rtl/flash_query_resp.sv
module flash_query_resp #(
  parameter int DEV_LOG2   = 24,
  parameter int ERASE_LOG2 = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  rd_en,
  input  logic [1:0]                            rd_mode,
  input  logic [1:0]                            rd_size,
  input  logic [DEV_LOG2-1:0]                   rd_addr,
  input  logic [7:0]                            status,
  input  logic [(1<<(DEV_LOG2-ERASE_LOG2))-1:0] lock_bits,
  output logic                                  rd_valid,
  output logic [31:0]                           rd_data
);

  localparam int BLK_W  = DEV_LOG2 - ERASE_LOG2;
  localparam int NBLK   = 1 << BLK_W;
  localparam int OFF_W  = DEV_LOG2 - 2;
  localparam logic [OFF_W-1:0] Q_LAST = OFF_W'(8'h43);
  localparam logic [15:0] CNT_M1   = 16'(NBLK - 1);
  localparam logic [15:0] BLK_UNIT = 16'(1 << (ERASE_LOG2 - 9));
  localparam logic [7:0]  SIZE_B   = 8'(DEV_LOG2 - 1);

  typedef enum logic [1:0] {M_STATUS, M_IDENT, M_QUERY, M_NONE} mode_t;

  mode_t             mode;
  logic [OFF_W-1:0]  q_off;
  logic [7:0]        q_byte;
  logic [7:0]        q_tab;
  logic [8:0]        id_idx;
  logic [BLK_W-1:0]  blk;
  logic [15:0]       id_val;
  logic [15:0]       val;
  logic [31:0]       lane;

  assign mode   = mode_t'(rd_mode);
  assign q_off  = rd_addr[DEV_LOG2-1:2];
  assign id_idx = rd_addr[10:2];
  assign blk    = rd_addr[DEV_LOG2-1:ERASE_LOG2];

  always_comb begin
    case (q_off[7:0])
      8'h10:   q_tab = 8'h51;
      8'h11:   q_tab = 8'h52;
      8'h12:   q_tab = 8'h59;
      8'h27:   q_tab = SIZE_B;
      8'h2D:   q_tab = CNT_M1[7:0];
      8'h2E:   q_tab = CNT_M1[15:8];
      8'h2F:   q_tab = BLK_UNIT[7:0];
      8'h30:   q_tab = BLK_UNIT[15:8];
      8'h31:   q_tab = 8'h50;
      8'h32:   q_tab = 8'h52;
      8'h33:   q_tab = 8'h49;
      default: q_tab = 8'h00;
    endcase
  end

  assign q_byte = (q_off <= Q_LAST) ? q_tab : 8'h00;

  always_comb begin
    case (id_idx)
      9'd0:    id_val = 16'h0000;
      9'd1:    id_val = 16'hFFFF;
      9'd2:    id_val = {15'b0, lock_bits[blk]};
      default: id_val = 16'h0000;
    endcase
  end

  always_comb begin
    case (mode)
      M_STATUS: val = {8'h00, status};
      M_IDENT:  val = id_val;
      M_QUERY:  val = {8'h00, q_byte};
      default:  val = 16'h0000;
    endcase
  end

  always_comb begin
    case (rd_size)
      2'd0:    lane = {24'h0, val[7:0]};
      2'd1:    lane = {16'h0, val};
      default: lane = {val, val};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 32'h0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= lane;
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid); // R2
  AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) (!rd_en && $past(rst_n)) |=> $stable(rd_data)); // R12
  AST_WORD_MIRRORED: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rd_size[1]) |=> (rd_data[31:16] == rd_data[15:0])); // R10
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rd_size == 2'd0) |=> (rd_data[31:8] == 24'h0)); // R10
  AST_STATUS_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rd_mode == 2'd0 && rd_size != 2'd0) |=> (rd_data[15:8] == 8'h00 && rd_data[7:0] == $past(status))); // R11
  AST_NONE_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rd_mode == 2'd3) |=> (rd_data == 32'h0)); // R12

endmodule

// File: tb/sim_flash_query_resp.sv
module sim_flash_query_resp;
  localparam int DEV_LOG2   = 24;
  localparam int ERASE_LOG2 = 16;
  localparam int NBLK       = 1 << (DEV_LOG2 - ERASE_LOG2);

  logic              clk = 0;
  logic              rst_n = 0;
  logic              rd_en = 0;
  logic [1:0]        rd_mode = 0;
  logic [1:0]        rd_size = 0;
  logic [DEV_LOG2-1:0] rd_addr = 0;
  logic [7:0]        status = 8'h80;
  logic [NBLK-1:0]   lock_bits = '0;
  logic              rd_valid;
  logic [31:0]       rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        exp_valid = 0;
  logic [31:0] exp_data  = 0;
  string       exp_tag   = "R1";

  always #2 clk = ~clk;

  flash_query_resp #(.DEV_LOG2(DEV_LOG2), .ERASE_LOG2(ERASE_LOG2)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_mode(rd_mode), .rd_size(rd_size),
    .rd_addr(rd_addr), .status(status), .lock_bits(lock_bits),
    .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic int ref16(int m, int a);
    int q, idx, v;
    v = 0;
    if (m == 0) v = status;
    else if (m == 1) begin
      idx = (a & 'h7ff) / 4;
      if (idx == 0) v = 0;
      else if (idx == 1) v = 'hffff;
      else if (idx == 2) v = lock_bits[a / (1 << ERASE_LOG2)] ? 1 : 0;
    end else if (m == 2) begin
      q = a / 4;
      case (q)
        'h10: v = "Q";
        'h11: v = "R";
        'h12: v = "Y";
        'h31: v = "P";
        'h32: v = "R";
        'h33: v = "I";
        'h27: v = DEV_LOG2 - 1;
        'h2d: v = (NBLK - 1) % 256;
        'h2e: v = (NBLK - 1) / 256;
        'h2f: v = ((1 << (ERASE_LOG2 - 1)) / 256) % 256;
        'h30: v = ((1 << (ERASE_LOG2 - 1)) / 256) / 256;
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  function automatic string tag_of(int m, int s, int a);
    int q;
    if (m == 3) return "R12";
    if (s != 2) return "R10";
    if (m == 0) return "R11";
    if (m == 1) return (((a & 'h7ff) / 4) == 2) ? "R9" : "R8";
    q = a / 4;
    if ((q >= 'h10 && q <= 'h12) || (q >= 'h31 && q <= 'h33)) return "R3";
    if (q == 'h27) return "R4";
    if (q == 'h2d || q == 'h2e) return "R5";
    if (q == 'h2f || q == 'h30) return "R6";
    return "R7";
  endfunction

  always @(posedge clk) begin
    int v;
    if (!rst_n) begin
      exp_valid <= 0;
      exp_data  <= 0;
      exp_tag   <= "R1";
    end else begin
      exp_valid <= rd_en;
      if (rd_en) begin
        v = ref16(rd_mode, rd_addr);
        if (rd_size == 0) exp_data <= 32'(v % 256);
        else if (rd_size == 1) exp_data <= 32'(v);
        else exp_data <= {v[15:0], v[15:0]};
        exp_tag <= tag_of(rd_mode, rd_size, rd_addr);
      end else exp_tag <= "R12";
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rd_valid !== exp_valid) begin
        fails++;
        $display("FAIL R2: rd_valid actual %0b expected %0b", rd_valid, exp_valid);
      end
      checks++;
      if (rd_data !== exp_data) begin
        fails++;
        $display("FAIL %s: rd_data actual %08h expected %08h", exp_tag, rd_data, exp_data);
      end
    end
  end

  task automatic rd(input int m, input int s, input int a);
    rd_mode = 2'(m); rd_size = 2'(s); rd_addr = DEV_LOG2'(a); rd_en = 1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    rd_en = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state observed by the per-cycle compare above
    rd(2, 2, 'h10 * 4); rd(2, 2, 'h11 * 4); rd(2, 2, 'h12 * 4 + 3);
    rd(2, 2, 'h31 * 4); rd(2, 2, 'h32 * 4); rd(2, 2, 'h33 * 4);        // R3
    rd(2, 2, 'h27 * 4);                                                // R4
    rd(2, 2, 'h2d * 4); rd(2, 2, 'h2e * 4);                            // R5
    rd(2, 2, 'h2f * 4); rd(2, 2, 'h30 * 4);                            // R6
    rd(2, 2, 'h44 * 4); rd(2, 2, 'h13 * 4); rd(2, 2, 'h400 * 4);       // R7
    rd(2, 0, 'h10 * 4); rd(2, 1, 'h11 * 4); rd(2, 3, 'h12 * 4);        // R10
    idle(3);                                                           // R12 hold
    rd(1, 2, 0); rd(1, 2, 4); rd(1, 2, 12); rd(1, 2, 'h7fc);           // R8
    rd(1, 2, 'h804); rd(1, 0, 4); rd(1, 1, 4);
    lock_bits[5] = 1;
    rd(1, 2, (5 << 16) | 8); rd(1, 2, (6 << 16) | 8);                  // R9
    lock_bits[5] = 0; rd(1, 2, (5 << 16) | 8);                         // R9 same-edge change
    lock_bits[255] = 1; rd(1, 2, (255 << 16) | 'h808);
    status = 8'hB2; rd(0, 2, 0); rd(0, 1, 0); rd(0, 0, 0);             // R11
    status = 8'h80; rd(0, 2, 'h100);
    rd(3, 2, 'h10 * 4); idle(2);                                       // R12
    for (int i = 0; i < 600; i++) begin
      int m, s, a;
      m = $urandom % 4; s = $urandom % 4;
      a = ($urandom % 3 == 0) ? ($urandom % (1 << DEV_LOG2)) : ($urandom % 'h140);
      if ($urandom % 4 == 0) a = ((($urandom % NBLK) << 16) | 8);
      if ($urandom % 3 == 0) lock_bits[$urandom % NBLK] = $urandom % 2;
      if ($urandom % 4 == 0) status = 8'($urandom);
      if ($urandom % 5 == 0) idle(1 + $urandom % 2);
      else rd(m, s, a);
    end
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule